// File: doc/BRIEF.md
# Interval Time-Base Timer

This block is a continuously running binary up-counter that advances on each cycle where an internal count-enable strobe is high. A two-bit interval select picks one of four counter bits as the period tap. Each time that tap wraps from 1 to 0 the block latches a sticky overflow flag. When the interrupt enable is also set, the flag drives a level interrupt request. Software then acknowledges the interrupt by writing zero to the flag.

A single narrow control register covers the whole interface. One write can update the enable and the interval select, acknowledge the flag and restart the counter from zero. Reads return the live enable, flag and select. The counter value is also driven out so that neighbouring logic can use it as a time base. A counter restart that falls on the same cycle as a tap wrap takes precedence, and the flag stays clear.

Top module: `ivt_timer`

## Requirements
- R1: The counter increments by one on each clock where `cnt_en` is 1, holds its value where `cnt_en` is 0, and wraps from all ones to zero.
- R2: Interval select values 0, 1, 2 and 3 choose the taps given by the `TAPS` parameter (default bits 12, 14, 16, 21). An overflow is an incrementing cycle on which the counter bits from the tap down to bit 0 are all ones. On the following clock edge the flag becomes 1.
- R3: The flag is set by an overflow whatever the interrupt enable holds, and it stays at 1 until a register write clears it.
- R4: `irq` is 1 exactly while the enable and the flag are both 1. A write that sets the enable while the flag is pending raises `irq` in the cycle after the write.
- R5: A register write with bit 1 = 0 clears the flag, and bit 1 = 1 leaves it unchanged. If an overflow (without a restart) falls in the same cycle as a clearing write, the flag ends up at 1.
- R6: A register write with bit 2 = 1 sets the counter to zero on that edge, whether or not `cnt_en` is high. An overflow in that same cycle does not set the flag.
- R7: A single write with bit 0 = 1 and bit 1 = 0 that coincides with no overflow leaves `irq` at 0 in the next cycle, even if the flag was pending before.
- R8: Register layout, for both write and read: bit 0 is the interrupt enable, bit 1 the flag, bit 2 the restart command (always read as 1), and bits 4:3 the interval select. Any write loads the enable and the select.
- R9: After reset, the counter, flag, enable and select are all 0. `irq` is 0 and `rd_data` reads 5'b00100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count strobe; the counter advances on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write value |
| rd_data | output | 5 | Register read value |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Interrupt request level |

## Verification
Two events can fall on the same edge: a tap wrap and a register write. The write may restart the counter, or it may acknowledge the flag. The bench steps the counter until the bits under the tap are all ones and issues the write on that exact cycle. With a restart, the counter must read zero and the flag must stay clear. With an acknowledge, the flag must stay set. Both are judged against a cycle-accurate arithmetic model kept in the bench, which also runs an exhaustive sweep over every select and both enable settings on a reduced 8-bit counter.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int unsigned SEL_W      = 2;
    localparam int unsigned NUM_TAPS   = 1 << SEL_W;

    // register field positions (software-visible layout)
    localparam int unsigned BIT_IE     = 0;
    localparam int unsigned BIT_FLAG   = 1;
    localparam int unsigned BIT_CLR    = 2;
    localparam int unsigned BIT_SEL_LO = 3;
    localparam int unsigned REG_W      = BIT_SEL_LO + SEL_W;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic ie;
        logic flag;
        sel_t sel;
    } ctrl_state_t;

    typedef struct packed {
        logic wr;
        logic ie;
        logic flag_wr;
        logic clr;
        sel_t sel;
    } reg_write_t;

    function automatic reg_write_t decode_write(input logic en, input logic [REG_W-1:0] d);
        reg_write_t w;
        w.wr      = en;
        w.ie      = d[BIT_IE];
        w.flag_wr = d[BIT_FLAG];
        w.clr     = d[BIT_CLR];
        w.sel     = d[BIT_SEL_LO +: SEL_W];
        return w;
    endfunction

endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d.cnt = '0;
        end else if (cnt_en) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_q = state_q.cnt;

    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && !clr |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en && !clr |=> $stable(cnt_q));

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/ivt_tap_detect.sv
module ivt_tap_detect
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned TAPS [NUM_TAPS] = '{12, 14, 16, 21}
) (
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt,
    input  sel_t             sel,
    output logic             ovf
);

    // a tap wraps on an increment when it and every bit below it are ones
    logic [NUM_TAPS-1:0] full;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign full[g] = &cnt[TAPS[g]:0];
    end

    always_comb begin
        ovf = cnt_en & full[sel];
    end

endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  reg_write_t       wr,
    input  logic             ovf,
    output logic             clr,
    output sel_t             sel,
    output logic             irq,
    output logic [REG_W-1:0] rd_data
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        clr  = wr.wr & wr.clr;
        st_d = st_q;
        if (wr.wr) begin
            st_d.ie  = wr.ie;
            st_d.sel = wr.sel;
            if (!wr.flag_wr) begin
                st_d.flag = 1'b0;
            end
        end
        // a wrap wins over an acknowledge, a restart wins over a wrap
        if (ovf && !clr) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel                          = st_q.sel;
        irq                          = st_q.ie & st_q.flag;
        rd_data                      = '0;
        rd_data[BIT_IE]              = st_q.ie;
        rd_data[BIT_FLAG]            = st_q.flag;
        rd_data[BIT_CLR]             = 1'b1;
        rd_data[BIT_SEL_LO +: SEL_W] = st_q.sel;
    end

    a_r3_flag_set_any_ie: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> st_q.flag);

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag && !(wr.wr && !wr.flag_wr) |=> st_q.flag);

    a_r5_write_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr.wr && wr.flag_wr && !st_q.flag && !ovf |=> !st_q.flag);

    a_r6_clear_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !st_q.flag |=> !st_q.flag);

    a_r4_enable_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr.wr && wr.ie && wr.flag_wr && st_q.flag |=> irq);

    a_r7_no_stale_request: assert property (@(posedge clk) disable iff (!rst_n)
        wr.wr && wr.ie && !wr.flag_wr && !ovf |=> !irq);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned TAPS [NUM_TAPS] = '{12, 14, 16, 21}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    reg_write_t wr_s;
    logic       clr_w;
    logic       ovf_w;
    sel_t       sel_w;

    always_comb begin
        wr_s = decode_write(wr_en, wr_data);
    end

    ivt_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .clr    (clr_w),
        .cnt_q  (count)
    );

    ivt_tap_detect #(
        .CNT_W (CNT_W),
        .TAPS  (TAPS)
    ) i_tap (
        .cnt_en (cnt_en),
        .cnt    (count),
        .sel    (sel_w),
        .ovf    (ovf_w)
    );

    ivt_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_s),
        .ovf     (ovf_w),
        .clr     (clr_w),
        .sel     (sel_w),
        .irq     (irq),
        .rd_data (rd_data)
    );

    a_r2_wrap_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_w && !(wr_en && wr_data[BIT_CLR]) |=> rd_data[BIT_FLAG]);

endmodule

// File: tb/test_ivt_timer.sv
module test_ivt_timer;

    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned TB_CNT_W = 8;
    localparam int unsigned TB_TAPS [4] = '{1, 3, 5, 7};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cnt_en = 1'b0;
    logic                wr_en = 1'b0;
    logic [4:0]          wr_data = '0;
    logic [4:0]          rd_data;
    logic [TB_CNT_W-1:0] count;
    logic                irq;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] m_cnt = '0;
    logic       m_ie = 1'b0;
    logic       m_flag = 1'b0;
    logic [1:0] m_sel = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivt_timer #(
        .CNT_W (TB_CNT_W),
        .TAPS  (TB_TAPS)
    ) i_ivt_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .count   (count),
        .irq     (irq)
    );

    function automatic logic [4:0] wd(input logic ie, input logic flag, input logic clr, input logic [1:0] sel);
        return {sel, clr, flag, ie};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "count", 32'(count), 32'(m_cnt));
        check(req, "irq", 32'(irq), 32'(m_ie && m_flag));
        check(req, "rd_data", 32'(rd_data), 32'({m_sel, 1'b1, m_flag, m_ie}));
    endtask

    task automatic step(input string req, input logic en, input logic we, input logic [4:0] d);
        int unsigned tap;
        logic [7:0]  mask;
        logic        clr_e;
        logic        ovf_e;
        @(negedge clk);
        cnt_en  = en;
        wr_en   = we;
        wr_data = d;
        tap   = TB_TAPS[m_sel];
        mask  = 8'((2 ** (tap + 1)) - 1);
        clr_e = we && d[2];
        ovf_e = en && ((m_cnt & mask) == mask);
        if (clr_e) m_cnt = '0;
        else if (en) m_cnt = m_cnt + 8'd1;
        if (we) begin
            m_ie  = d[0];
            m_sel = d[4:3];
            if (!d[1]) m_flag = 1'b0;
        end
        if (ovf_e && !clr_e) m_flag = 1'b1;
        @(posedge clk);
        #1;
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_all("R9");
        rst_n = 1'b1;

        // R1: counting with a gapped strobe, no writes
        for (int k = 0; k < 30; k++) step("R1", (k % 3) != 0, 1'b0, 5'd0);

        // R2 (enable on, acknowledged) and R3 (enable off, flag sticky), every select
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                string tg;
                tg = (e == 1) ? "R2" : "R3";
                step(tg, 1'b1, 1'b1, wd(e[0], 1'b0, 1'b1, s[1:0]));
                for (int k = 0; k < 340; k++) begin
                    if (e == 1 && m_flag) step(tg, (k % 5) != 4, 1'b1, wd(1'b1, 1'b0, 1'b0, s[1:0]));
                    else step(tg, (k % 5) != 4, 1'b0, 5'd0);
                end
            end
        end

        // R6: restart exactly on a wrap, select 0
        step("R6", 1'b0, 1'b1, wd(1'b0, 1'b0, 1'b1, 2'd0));
        while (m_cnt[1:0] != 2'b11) step("R6", 1'b1, 1'b0, 5'd0);
        step("R6", 1'b1, 1'b1, wd(1'b0, 1'b0, 1'b1, 2'd0));
        check("R6", "flag after collision", 32'(rd_data[1]), 32'd0);
        step("R6", 1'b1, 1'b0, 5'd0);
        step("R6", 1'b0, 1'b1, wd(1'b0, 1'b0, 1'b1, 2'd0));

        // R5: acknowledge coinciding with wrap, then write-one and write-zero
        while (m_cnt[1:0] != 2'b11) step("R5", 1'b1, 1'b0, 5'd0);
        step("R5", 1'b1, 1'b1, wd(1'b0, 1'b0, 1'b0, 2'd0));
        check("R5", "flag set wins", 32'(rd_data[1]), 32'd1);
        step("R5", 1'b0, 1'b1, wd(1'b0, 1'b1, 1'b0, 2'd0));
        step("R5", 1'b0, 1'b1, wd(1'b0, 1'b0, 1'b0, 2'd0));
        step("R5", 1'b0, 1'b1, wd(1'b0, 1'b1, 1'b0, 2'd0));

        // R4: enabling with a pending flag
        while (!m_flag) step("R4", 1'b1, 1'b0, 5'd0);
        step("R4", 1'b0, 1'b1, wd(1'b1, 1'b1, 1'b0, 2'd0));
        check("R4", "irq after enable", 32'(irq), 32'd1);
        step("R4", 1'b0, 1'b1, wd(1'b1, 1'b0, 1'b0, 2'd0));

        // R7: enable plus acknowledge in one write
        step("R7", 1'b0, 1'b1, wd(1'b0, 1'b0, 1'b0, 2'd0));
        while (!m_flag) step("R7", 1'b1, 1'b0, 5'd0);
        step("R7", 1'b0, 1'b1, wd(1'b1, 1'b0, 1'b0, 2'd0));
        check("R7", "irq after combined write", 32'(irq), 32'd0);

        // R8: layout read-back with select 3 and both bits set
        while (!m_flag) step("R8", 1'b1, 1'b0, 5'd0);
        step("R8", 1'b0, 1'b1, wd(1'b1, 1'b1, 1'b0, 2'd3));
        check("R8", "rd_data layout", 32'(rd_data), 32'h1F);
        for (int k = 0; k < 10; k++) step("R8", 1'b0, 1'b0, 5'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule